// File: doc/BRIEF.md
# Floppy Controller Host Command Front End

This block is the host-side register front end of a floppy disk controller. A host reaches it through a small byte-wide register window. One register controls the drives: it selects a unit, turns on the motors, gates the interrupt output and can hold the controller in reset. One register sets the transfer rate. A status register paces the host, and a single data port carries every command byte the host writes and every result byte it reads back.

Each command starts with an opcode byte. The opcode fixes how many parameter bytes follow, whether an execution phase runs, and how many result bytes come back. The data port reverses direction when the result phase begins. Two status flags tell the host when it may move a byte and in which direction. Seek, recalibrate, read and write run a timed execution phase and then raise a pending interrupt. The sense-interrupt command reports the outcome and clears that interrupt.

The disk behind the controller is a stub. It keeps a present cylinder for each unit and returns fixed results. The sector data path and DMA are not modelled.

Top module: `fdc_host_front`

## Requirements
- R1: After reset, the drive-control register reads 0x00, the status register reads 0x00, the motor enables and the interrupt output are low, and the controller is held in reset.
- R2: The drive-control register is at offset 2. Its bits 1:0 drive `drive_sel`, bit 2 (high) releases the controller from reset, bit 3 drives `io_gate_en`, and bits 7:4 drive `motor_en`. A write to offset 7 sets `rate_sel` from data bits 1:0.
- R3: While drive-control bit 2 is low, the status register (offset 4) reads 0x00, data-port writes are ignored, and every unit's cylinder returns to 0.
- R4: The status register reports bit7 = ready for a host byte, bit6 = controller-to-host direction, bit5 = execution running with drive-control bit 3 clear, and bit4 = command in progress. The resulting values are 0x80 when idle, 0x90 while parameters are being collected, 0x10 or 0x30 during execution, and 0xD0 while results are pending.
- R5: The opcode is decoded from data bits 4:0 only. Opcode 0x10 takes no parameters and returns the single byte 0x90, after which the block is idle.
- R6: Opcode 0x0F takes a unit byte and a cylinder byte, runs `EXEC_CYCLES` cycles of execution, returns no result bytes and sets the pending interrupt. Opcode 0x08 then returns status 0 (0x20 OR unit) followed by the present cylinder, and clears the pending interrupt.
- R7: Opcode 0x07 takes one unit byte, sets that unit's cylinder to 0 and sets the pending interrupt. The next 0x08 returns 0x20 OR unit, then 0x00.
- R8: Opcodes 0x06 (read) and 0x05 (write) each take eight parameter bytes: head/unit, C, H, R, N, end of track, gap, data length. After execution they set the pending interrupt and return seven bytes: head/unit bits 2:0, 0x00, 0x00, C, H, R, N.
- R9: Opcode 0x03 takes two parameter bytes, returns no result bytes, raises no interrupt and leaves the block idle.
- R10: Opcode 0x04 takes one byte (head<<2 | unit) and returns one byte. That byte is 0x20, OR 0x10 when the unit's cylinder is 0, OR the parameter's bits 2:0.
- R11: Any other opcode returns the single byte 0x80 and then leaves the block idle.
- R12: A data-port read while the direction flag is 0 returns 0x00 and changes nothing. A data-port write while the direction flag is 1 is ignored, and the result sequence continues unchanged.
- R13: `irq_out` is high only when an interrupt is pending and drive-control bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset from the base |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq_out | output | 1 | Gated interrupt request |
| drive_sel | output | 2 | Selected unit |
| motor_en | output | 4 | Motor enables for units 0 to 3 |
| io_gate_en | output | 1 | Gate enable for the DMA and interrupt outputs |
| rate_sel | output | RATE_W | Data rate code |

## Verification
A wrong phase shows up at the next status read. The ready and direction flags disagree with the bytes already written, so a parameter miscount is visible one status read after the last byte, well before any result is drawn. A stale cylinder or status byte does not surface until the next sense command and only affects that command's two bytes. For this reason the bench follows every motion command with a sense command. An interrupt that is never raised or never cleared is visible on `irq_out` in the cycle the status register shows ready again.

// File: rtl/fdc_pkg.sv
// Shared phase type, opcode values and per-opcode counts for the host front end.
// Assumes opcodes are decoded from the low five bits of the command byte.
package fdc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_PARAM  = 2'd1,
        PH_EXEC   = 2'd2,
        PH_RESULT = 2'd3
    } phase_t;

    localparam logic [4:0] OP_SPECIFY  = 5'h03;
    localparam logic [4:0] OP_DRVSTAT  = 5'h04;
    localparam logic [4:0] OP_WRITE    = 5'h05;
    localparam logic [4:0] OP_READ     = 5'h06;
    localparam logic [4:0] OP_RECAL    = 5'h07;
    localparam logic [4:0] OP_SENSEINT = 5'h08;
    localparam logic [4:0] OP_SEEK     = 5'h0F;
    localparam logic [4:0] OP_VERSION  = 5'h10;

    localparam logic [7:0] VERSION_ID  = 8'h90;
    localparam logic [7:0] ST0_INVALID = 8'h80;
    localparam logic [7:0] ST0_SEEKEND = 8'h20;
    localparam logic [7:0] ST3_READY   = 8'h20;
    localparam logic [7:0] ST3_TRACK0  = 8'h10;

    // Number of parameter bytes that follow each opcode.
    function automatic logic [3:0] param_count(input logic [4:0] op);
        case (op)
            OP_SPECIFY: return 4'd2;
            OP_DRVSTAT: return 4'd1;
            OP_WRITE:   return 4'd8;
            OP_READ:    return 4'd8;
            OP_RECAL:   return 4'd1;
            OP_SEEK:    return 4'd2;
            default:    return 4'd0;
        endcase
    endfunction

    // Number of result bytes returned for each opcode.
    function automatic logic [3:0] result_count(input logic [4:0] op);
        case (op)
            OP_SPECIFY:  return 4'd0;
            OP_DRVSTAT:  return 4'd1;
            OP_WRITE:    return 4'd7;
            OP_READ:     return 4'd7;
            OP_RECAL:    return 4'd0;
            OP_SEEK:     return 4'd0;
            OP_SENSEINT: return 4'd2;
            default:     return 4'd1;
        endcase
    endfunction

    // True for opcodes that run a timed execution phase and raise the interrupt.
    function automatic logic needs_exec(input logic [4:0] op);
        return (op == OP_SEEK) || (op == OP_RECAL) || (op == OP_READ) || (op == OP_WRITE);
    endfunction

    // Phase entered once the last parameter byte of an opcode has arrived.
    function automatic phase_t post_param_phase(input logic [4:0] op);
        if (needs_exec(op))
            return PH_EXEC;
        else if (result_count(op) != 4'd0)
            return PH_RESULT;
        else
            return PH_IDLE;
    endfunction

endpackage

// File: rtl/fdc_reg_decode.sv
// Host register decode: holds the drive-control and rate registers and turns
// bus strobes into data-port write/read pulses.
// Assumes one strobe per byte and that read and write are never both high.
module fdc_reg_decode #(
    parameter int ADDR_W   = 3,
    parameter int RATE_W   = 2,
    parameter int DOR_OFS  = 2,
    parameter int MSR_OFS  = 4,
    parameter int DATA_OFS = 5,
    parameter int RATE_OFS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        dor_q,
    output logic [RATE_W-1:0] rate_q,
    output logic              data_wr,
    output logic              data_rd,
    output logic              sel_dor,
    output logic              sel_msr,
    output logic              sel_data
);

    // Offset decode for the three readable registers.
    always_comb begin
        sel_dor  = (addr == ADDR_W'(DOR_OFS));
        sel_msr  = (addr == ADDR_W'(MSR_OFS));
        sel_data = (addr == ADDR_W'(DATA_OFS));
        data_wr  = wr_en && sel_data;
        data_rd  = rd_en && sel_data;
    end

    // Drive-control and rate register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dor_q  <= 8'h00;
            rate_q <= '0;
        end else if (wr_en) begin
            if (sel_dor)
                dor_q <= wdata;
            if (addr == ADDR_W'(RATE_OFS))
                rate_q <= wdata[RATE_W-1:0];
        end
    end

endmodule

// File: rtl/fdc_cmd_seq.sv
// Command phase sequencer: collects the opcode and its parameters, times the
// execution phase and steps through the result bytes.
// Assumes MAX_PARAMS is at least the longest parameter list (eight bytes).
module fdc_cmd_seq
    import fdc_pkg::*;
#(
    parameter int MAX_PARAMS  = 8,
    parameter int EXEC_CYCLES = 16,
    localparam int IDX_W      = $clog2(MAX_PARAMS + 1),
    localparam int CNT_W      = $clog2(EXEC_CYCLES + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hold,
    input  logic                         data_wr,
    input  logic                         data_rd,
    input  logic [7:0]                   wdata,
    output phase_t                       phase,
    output logic [4:0]                   cmd,
    output logic [MAX_PARAMS-1:0][7:0]   params,
    output logic [IDX_W-1:0]             res_idx,
    output logic                         cmd_start,
    output logic                         exec_done
);

    logic [IDX_W-1:0] par_idx;
    logic [CNT_W-1:0] ecnt;
    logic [3:0]       np_cur;
    logic [3:0]       nr_cur;

    // Counts for the command currently held.
    always_comb begin
        np_cur    = param_count(cmd);
        nr_cur    = result_count(cmd);
        cmd_start = (phase == PH_IDLE) && data_wr && !hold;
        exec_done = (phase == PH_EXEC) && (ecnt == CNT_W'(EXEC_CYCLES - 1)) && !hold;
    end

    // Phase register and byte counters.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            phase   <= PH_IDLE;
            cmd     <= 5'd0;
            params  <= '0;
            par_idx <= '0;
            res_idx <= '0;
            ecnt    <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (data_wr) begin
                        cmd     <= wdata[4:0];
                        par_idx <= '0;
                        res_idx <= '0;
                        ecnt    <= '0;
                        if (param_count(wdata[4:0]) == 4'd0)
                            phase <= post_param_phase(wdata[4:0]);
                        else
                            phase <= PH_PARAM;
                    end
                end
                PH_PARAM: begin
                    if (data_wr) begin
                        params[par_idx] <= wdata;
                        if (par_idx == IDX_W'(np_cur - 4'd1))
                            phase <= post_param_phase(cmd);
                        else
                            par_idx <= par_idx + 1'b1;
                    end
                end
                PH_EXEC: begin
                    ecnt <= ecnt + 1'b1;
                    if (exec_done)
                        phase <= (nr_cur != 4'd0) ? PH_RESULT : PH_IDLE;
                end
                PH_RESULT: begin
                    if (data_rd) begin
                        if (res_idx == IDX_W'(nr_cur - 4'd1))
                            phase <= PH_IDLE;
                        else
                            res_idx <= res_idx + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fdc_exec_stub.sv
// Executor stub: keeps each unit's present cylinder and the last seek status,
// owns the pending interrupt and forms the result byte being presented.
// Assumes N_UNITS is at most 4, so the unit number fits in two bits.
module fdc_exec_stub
    import fdc_pkg::*;
#(
    parameter int MAX_PARAMS = 8,
    parameter int N_UNITS    = 4,
    localparam int IDX_W     = $clog2(MAX_PARAMS + 1),
    localparam int UNIT_W    = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hold,
    input  logic [4:0]                 cmd,
    input  logic [MAX_PARAMS-1:0][7:0] params,
    input  logic [IDX_W-1:0]           res_idx,
    input  logic                       cmd_start,
    input  logic [4:0]                 start_op,
    input  logic                       exec_done,
    output logic                       irq_pend,
    output logic [7:0]                 res_byte
);

    logic [7:0]        cyl [N_UNITS];
    logic [7:0]        st0_last;
    logic [7:0]        pcn_last;
    logic [UNIT_W-1:0] unit;
    logic [7:0]        st3;

    // Unit field and drive-status byte for the held command.
    always_comb begin
        unit = params[0][UNIT_W-1:0];
        st3  = ST3_READY | ((cyl[unit] == 8'd0) ? ST3_TRACK0 : 8'h00) | {5'd0, params[0][2:0]};
    end

    // Cylinder model, seek status and pending interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            for (int i = 0; i < N_UNITS; i++)
                cyl[i] <= 8'd0;
            st0_last <= 8'd0;
            pcn_last <= 8'd0;
            irq_pend <= 1'b0;
        end else begin
            if (exec_done) begin
                case (cmd)
                    OP_SEEK: begin
                        cyl[unit] <= params[1];
                        st0_last  <= ST0_SEEKEND | 8'(unit);
                        pcn_last  <= params[1];
                        irq_pend  <= 1'b1;
                    end
                    OP_RECAL: begin
                        cyl[unit] <= 8'd0;
                        st0_last  <= ST0_SEEKEND | 8'(unit);
                        pcn_last  <= 8'd0;
                        irq_pend  <= 1'b1;
                    end
                    OP_READ, OP_WRITE: irq_pend <= 1'b1;
                    default: ;
                endcase
            end
            if (cmd_start && (start_op == OP_SENSEINT))
                irq_pend <= 1'b0;
        end
    end

    // Result byte selected by opcode and result index.
    always_comb begin
        case (cmd)
            OP_VERSION:  res_byte = VERSION_ID;
            OP_SENSEINT: res_byte = (res_idx == '0) ? st0_last : pcn_last;
            OP_DRVSTAT:  res_byte = st3;
            OP_READ, OP_WRITE: begin
                case (res_idx)
                    IDX_W'(0): res_byte = {5'd0, params[0][2:0]};
                    IDX_W'(3): res_byte = params[1];
                    IDX_W'(4): res_byte = params[2];
                    IDX_W'(5): res_byte = params[3];
                    IDX_W'(6): res_byte = params[4];
                    default:   res_byte = 8'h00;
                endcase
            end
            default: res_byte = ST0_INVALID;
        endcase
    end

endmodule

// File: rtl/fdc_host_front.sv
// Top of the host front end: register window, command sequencer and executor
// stub, with the status register and read-data mux formed here.
// Assumes the host polls the status register before every data-port access.
module fdc_host_front
    import fdc_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int RATE_W      = 2,
    parameter int N_UNITS     = 4,
    parameter int MAX_PARAMS  = 8,
    parameter int EXEC_CYCLES = 16,
    localparam int IDX_W      = $clog2(MAX_PARAMS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq_out,
    output logic [1:0]        drive_sel,
    output logic [3:0]        motor_en,
    output logic              io_gate_en,
    output logic [RATE_W-1:0] rate_sel
);

    logic [7:0]                 dor_q;
    logic                       data_wr, data_rd;
    logic                       sel_dor, sel_msr, sel_data;
    logic                       hold;
    phase_t                     phase;
    logic [4:0]                 cmd;
    logic [MAX_PARAMS-1:0][7:0] params;
    logic [IDX_W-1:0]           res_idx;
    logic                       cmd_start, exec_done;
    logic                       irq_pend;
    logic [7:0]                 res_byte;
    logic [7:0]                 msr;

    fdc_reg_decode #(
        .ADDR_W (ADDR_W),
        .RATE_W (RATE_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .wdata    (bus_wdata),
        .dor_q    (dor_q),
        .rate_q   (rate_sel),
        .data_wr  (data_wr),
        .data_rd  (data_rd),
        .sel_dor  (sel_dor),
        .sel_msr  (sel_msr),
        .sel_data (sel_data)
    );

    fdc_cmd_seq #(
        .MAX_PARAMS  (MAX_PARAMS),
        .EXEC_CYCLES (EXEC_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .wdata     (bus_wdata),
        .phase     (phase),
        .cmd       (cmd),
        .params    (params),
        .res_idx   (res_idx),
        .cmd_start (cmd_start),
        .exec_done (exec_done)
    );

    fdc_exec_stub #(
        .MAX_PARAMS (MAX_PARAMS),
        .N_UNITS    (N_UNITS)
    ) u_stub (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .cmd       (cmd),
        .params    (params),
        .res_idx   (res_idx),
        .cmd_start (cmd_start),
        .start_op  (bus_wdata[4:0]),
        .exec_done (exec_done),
        .irq_pend  (irq_pend),
        .res_byte  (res_byte)
    );

    // Drive-control fields, reset hold and status flags.
    always_comb begin
        hold       = !dor_q[2];
        drive_sel  = dor_q[1:0];
        motor_en   = dor_q[7:4];
        io_gate_en = dor_q[3];
        irq_out    = irq_pend && dor_q[3];
        if (hold)
            msr = 8'h00;
        else
            msr = {phase != PH_EXEC, phase == PH_RESULT,
                   (phase == PH_EXEC) && !dor_q[3], phase != PH_IDLE, 4'b0000};
    end

    // Read-data mux across the readable registers.
    always_comb begin
        if (sel_dor)
            bus_rdata = dor_q;
        else if (sel_msr)
            bus_rdata = msr;
        else if (sel_data && (phase == PH_RESULT) && !hold)
            bus_rdata = res_byte;
        else
            bus_rdata = 8'h00;
    end

endmodule

// File: rtl/fdc_host_front_chk.sv
// Property checker for the host front end, attached by bind to its internals.
module fdc_host_front_chk
    import fdc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_out,
    input logic [7:0]       dor_q,
    input phase_t           phase,
    input logic [4:0]       cmd,
    input logic [IDX_W-1:0] res_idx,
    input logic             irq_pend,
    input logic             data_wr,
    input logic             data_rd
);

    // R13: the output never fires while the gate bit is clear.
    a_r13_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> dor_q[3]);

    // R3: holding the controller in reset returns the sequencer to idle.
    a_r3_hold_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !dor_q[2] |=> (phase == PH_IDLE));

    // R12: a data write during the result phase leaves the result position alone.
    a_r12_result_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RESULT && data_wr && !data_rd && dor_q[2]) |=>
        (phase == PH_RESULT && $stable(res_idx)));

    // R6: a pending interrupt only appears at the end of an execution phase.
    a_r6_irq_from_exec: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend) |-> ($past(phase) == PH_EXEC));

    // R5: the result index stays within the opcode's result count.
    a_r5_result_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RESULT) |-> (int'(res_idx) < int'(result_count(cmd))));

endmodule

bind fdc_host_front fdc_host_front_chk #(.IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_out  (irq_out),
    .dor_q    (dor_q),
    .phase    (phase),
    .cmd      (cmd),
    .res_idx  (res_idx),
    .irq_pend (irq_pend),
    .data_wr  (data_wr),
    .data_rd  (data_rd)
);

// File: tb/sim_fdc_host_front.sv
// Scoreboard bench: driver tasks queue expected result bytes, and a monitor
// compares every data-port read against the queue.
module sim_fdc_host_front;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_out;
    logic [1:0] drive_sel;
    logic [3:0] motor_en;
    logic       io_gate_en;
    logic [1:0] rate_sel;

    int         n_chk = 0;
    int         n_fail = 0;
    bit         mon_en = 1'b1;
    bit         done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    fdc_host_front u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_out    (irq_out),
        .drive_sel  (drive_sel),
        .motor_en   (motor_en),
        .io_gate_en (io_gate_en),
        .rate_sel   (rate_sel)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic expect_byte(input string tag, input logic [7:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic pull(input int n);
        logic [7:0] v;
        for (int i = 0; i < n; i++) rd_reg(3'd5, v);
    endtask

    task automatic check_msr(input string req, input logic [7:0] exp);
        logic [7:0] v;
        rd_reg(3'd4, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic wait_ready();
        logic [7:0] v;
        for (int i = 0; i < 200; i++) begin
            rd_reg(3'd4, v);
            if (v[7]) break;
        end
    endtask

    // Monitor: every data-port read is compared with the next expected byte.
    always @(negedge clk) begin
        #2;
        if (mon_en && bus_rd && bus_addr == 3'd5) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected data read", bus_rdata, 0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata == e, t, bus_rdata, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(3'd2, v); check(v == 8'h00, "R1 dor", v, 0);
        check_msr("R1 msr", 8'h00);
        check(irq_out == 1'b0 && motor_en == 4'h0, "R1 outputs", {irq_out, motor_en}, 0);

        // R2 drive-control fields and rate
        wr_reg(3'd2, 8'h1D);
        check(drive_sel == 2'd1 && motor_en == 4'h1 && io_gate_en, "R2 fields",
              {drive_sel, motor_en, io_gate_en}, {2'd1, 4'h1, 1'b1});
        wr_reg(3'd7, 8'h02);
        check(rate_sel == 2'd2, "R2 rate", rate_sel, 2);
        check_msr("R4 idle", 8'h80);

        // R5 version
        wr_reg(3'd5, 8'h10);
        check_msr("R4 result phase", 8'hD0);
        expect_byte("R5 version", 8'h90);
        pull(1);
        check_msr("R5 back to idle", 8'h80);

        // R12 read in the wrong direction
        mon_en = 1'b0;
        rd_reg(3'd5, v); check(v == 8'h00, "R12 idle read", v, 0);
        mon_en = 1'b1;
        check_msr("R12 idle unchanged", 8'h80);

        // R6 seek unit 1 to 0x27
        wr_reg(3'd5, 8'h0F);
        check_msr("R4 param phase", 8'h90);
        wr_reg(3'd5, 8'h01);
        wr_reg(3'd5, 8'h27);
        check_msr("R4 exec dma", 8'h10);
        wait_ready();
        check_msr("R6 idle after seek", 8'h80);
        check(irq_out == 1'b1, "R6 irq set", irq_out, 1);
        wr_reg(3'd5, 8'h04); wr_reg(3'd5, 8'h05);
        expect_byte("R10 drive status off track0", 8'h25);
        pull(1);
        wr_reg(3'd5, 8'h08);
        expect_byte("R6 sense st0", 8'h21);
        expect_byte("R6 sense cylinder", 8'h27);
        pull(2);
        check(irq_out == 1'b0, "R6 irq cleared", irq_out, 0);

        // R13 gated interrupt, seek unit 2 to 5
        wr_reg(3'd2, 8'h14);
        wr_reg(3'd5, 8'h0F); wr_reg(3'd5, 8'h02); wr_reg(3'd5, 8'h05);
        check_msr("R4 exec non-dma", 8'h30);
        wait_ready();
        check(irq_out == 1'b0, "R13 gated off", irq_out, 0);
        wr_reg(3'd2, 8'h1C);
        check(irq_out == 1'b1, "R13 gated on", irq_out, 1);
        wr_reg(3'd5, 8'h08);
        expect_byte("R6 sense st0 unit2", 8'h22);
        expect_byte("R6 sense cylinder 5", 8'h05);
        pull(2);

        // R7 recalibrate unit 1
        wr_reg(3'd5, 8'h07); wr_reg(3'd5, 8'h01);
        wait_ready();
        check(irq_out == 1'b1, "R7 irq set", irq_out, 1);
        wr_reg(3'd5, 8'h08);
        expect_byte("R7 sense st0", 8'h21);
        expect_byte("R7 sense cylinder", 8'h00);
        pull(2);
        wr_reg(3'd5, 8'h04); wr_reg(3'd5, 8'h01);
        expect_byte("R10 drive status track0", 8'h31);
        pull(1);

        // R8 read
        wr_reg(3'd5, 8'h46);
        foreach (v[i]) ;
        wr_reg(3'd5, 8'h04); wr_reg(3'd5, 8'h03); wr_reg(3'd5, 8'h01); wr_reg(3'd5, 8'h05);
        wr_reg(3'd5, 8'h02); wr_reg(3'd5, 8'h12); wr_reg(3'd5, 8'h1B); wr_reg(3'd5, 8'hFF);
        wait_ready();
        check(irq_out == 1'b1, "R8 irq after read", irq_out, 1);
        expect_byte("R8 read st0", 8'h04);
        expect_byte("R8 read st1", 8'h00);
        expect_byte("R8 read st2", 8'h00);
        pull(3);
        wr_reg(3'd5, 8'h55);
        check_msr("R12 write in result phase", 8'hD0);
        expect_byte("R8 read C", 8'h03);
        expect_byte("R8 read H", 8'h01);
        expect_byte("R8 read R", 8'h05);
        expect_byte("R8 read N", 8'h02);
        pull(4);
        check_msr("R8 idle after read", 8'h80);
        wr_reg(3'd5, 8'h08);
        expect_byte("R6 sense after read st0", 8'h21);
        expect_byte("R6 sense after read cyl", 8'h00);
        pull(2);

        // R8 write
        wr_reg(3'd5, 8'hC5);
        wr_reg(3'd5, 8'h00); wr_reg(3'd5, 8'h10); wr_reg(3'd5, 8'h00); wr_reg(3'd5, 8'h01);
        wr_reg(3'd5, 8'h02); wr_reg(3'd5, 8'h12); wr_reg(3'd5, 8'h1B); wr_reg(3'd5, 8'hFF);
        wait_ready();
        expect_byte("R8 write st0", 8'h00);
        expect_byte("R8 write st1", 8'h00);
        expect_byte("R8 write st2", 8'h00);
        expect_byte("R8 write C", 8'h10);
        expect_byte("R8 write H", 8'h00);
        expect_byte("R8 write R", 8'h01);
        expect_byte("R8 write N", 8'h02);
        pull(7);
        wr_reg(3'd5, 8'h08);
        expect_byte("R6 sense after write st0", 8'h21);
        expect_byte("R6 sense after write cyl", 8'h00);
        pull(2);

        // R9 specify
        wr_reg(3'd5, 8'h03); wr_reg(3'd5, 8'hDF); wr_reg(3'd5, 8'h02);
        check_msr("R9 idle after specify", 8'h80);
        check(irq_out == 1'b0, "R9 no irq", irq_out, 0);

        // R11 unknown opcode
        wr_reg(3'd5, 8'h1F);
        expect_byte("R11 invalid status", 8'h80);
        pull(1);
        check_msr("R11 idle after invalid", 8'h80);

        // R3 hold in reset
        wr_reg(3'd2, 8'h08);
        check_msr("R3 held msr", 8'h00);
        wr_reg(3'd5, 8'h10);
        wr_reg(3'd2, 8'h0C);
        check_msr("R3 write ignored while held", 8'h80);
        wr_reg(3'd5, 8'h04); wr_reg(3'd5, 8'h02);
        expect_byte("R3 cylinder cleared", 8'h32);
        pull(1);

        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule